// File: doc/BRIEF.md
# Store-to-Load Forwarding Unit

A small circular store queue with a load query port. Stores enter in three steps: an entry is allocated at the queue tail, its virtual address, physical address and byte mask are written, and later its data is written. Entries are freed oldest-first by a dequeue pulse. A load query presents a virtual address, a physical address, a byte mask over a 16-byte line, a precomputed mask of the queue entries that are older than the load, and the load's position in the queue.

For each byte lane the unit finds the youngest older store that covers that byte and forwards its data. The answer comes in two pipelined steps. One cycle after the query a fast hit mask, from the virtual-address match, is presented. One cycle later the final hit mask, from the physical-address match, is presented together with the merged load data (forwarded bytes over cache bytes) and status flags: data not ready, address not ready, and a mismatch between the virtual and physical match results. The caller uses these flags to replay or flush the load.

Top module: `sfwd_unit`

## Requirements
- R1: `alloc_i` allocates the entry at the tail; `alloc_idx_o` shows the index that the next allocation takes (0 after reset) and advances by one modulo 16 per allocation. `deq_i` frees the oldest allocated entry. Entries are indexed 0 to 15.
- R2: A store matches a load only when address bits [W-1:4] are equal, and a byte lane hits only when both the store mask and the load mask have that bit set. Only entries that are allocated, have an address, and are set in `ld_older_i` take part.
- R3: When several matching older stores cover a byte, the youngest supplies it: the search starts at entry `ld_pos_i`-1 and walks toward lower indices, wrapping from 0 to 15.
- R4: Bit b of the final mask set means data byte b is the chosen store's byte b; clear means it is byte b of `cache_data_i` sampled one cycle after the query.
- R5: One cycle after a valid query, `fast_hit_o` shows the lanes whose youngest virtual-address match has its data written, and `fast_data_nr_o` is set when any such chosen store lacks data.
- R6: Two cycles after a valid query, `resp_valid_o` is 1 and `hit_o` shows the lanes whose youngest physical-address match has its data written.
- R7: Two cycles after the query, `data_nr_o` is set when a lane's chosen physical-match store has no data yet; `data_nr_idx_o` is the youngest such store (search as in R3).
- R8: `addr_nr_o` is set when any older allocated entry has no address yet; `addr_nr_idx_o` is the youngest such entry (search as in R3).
- R9: `mismatch_o` is set when the set of older address-valid entries that overlap the load bytes by virtual line differs from that set by physical line.
- R10: `flush_i` clears both response stages on the next edge; a cycle with `ld_valid_i` low produces all-zero responses.
- R11: After reset no entry is allocated, `alloc_idx_o` is 0 and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Clears the response pipeline |
| alloc_i | input | 1 | Allocate entry at tail |
| alloc_idx_o | output | 4 | Index the next allocation takes |
| deq_i | input | 1 | Free the oldest entry |
| addr_we_i | input | 1 | Address and mask write |
| addr_idx_i | input | 4 | Entry for address write |
| addr_va_i | input | 39 | Store virtual address |
| addr_pa_i | input | 36 | Store physical address |
| addr_mask_i | input | 16 | Store byte mask |
| data_we_i | input | 1 | Data write |
| data_idx_i | input | 4 | Entry for data write |
| data_i | input | 128 | Store data, byte b in bits 8b+7:8b |
| ld_valid_i | input | 1 | Load query valid |
| ld_va_i | input | 39 | Load virtual address |
| ld_pa_i | input | 36 | Load physical address |
| ld_mask_i | input | 16 | Load byte mask |
| ld_older_i | input | 16 | Entries older than the load |
| ld_pos_i | input | 4 | Load position: first entry younger than the load |
| cache_data_i | input | 128 | Cache line data, one cycle after the query |
| fast_hit_o | output | 16 | Early hit mask (virtual match) |
| fast_data_nr_o | output | 1 | Early data-not-ready |
| resp_valid_o | output | 1 | Final response valid |
| hit_o | output | 16 | Final hit mask (physical match) |
| data_o | output | 128 | Merged load data |
| data_nr_o | output | 1 | Data not ready |
| data_nr_idx_o | output | 4 | Store lacking data |
| addr_nr_o | output | 1 | Address not ready |
| addr_nr_idx_o | output | 4 | Store lacking address |
| mismatch_o | output | 1 | Virtual and physical match sets differ |

## Verification
A wrong valid bit, pointer or stored field shows on the next query that covers the affected line: a wrong byte in `data_o`, a lane missing or extra in `fast_hit_o` one cycle after the query, or a wrong flag or index two cycles after it. The random mix concentrates stores on four lines with overlapping masks and picks load positions in the middle of the queue, so an error in the wrapping youngest-first search appears as a byte taken from an older store within a few queries. Pointer faults show at once on `alloc_idx_o` at each allocation.

// File: rtl/sfwd_pkg.sv
package sfwd_pkg;
  parameter int unsigned SQ_N  = 16;   // entries, power of two
  parameter int unsigned LANES = 16;   // bytes per line
  parameter int unsigned VA_W  = 39;
  parameter int unsigned PA_W  = 36;
  localparam int unsigned PTR_W  = $clog2(SQ_N);
  localparam int unsigned LOFS   = $clog2(LANES);
  localparam int unsigned DATA_W = LANES * 8;

  typedef struct packed {
    logic             dnr;
    logic [PTR_W-1:0] dnr_idx;
    logic             anr;
    logic [PTR_W-1:0] anr_idx;
    logic             mm;
  } flags_t;
endpackage

// File: rtl/sfwd_store_queue.sv
module sfwd_store_queue
  import sfwd_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              alloc_i,
  output logic [PTR_W-1:0]                  tail_o,
  input  logic                              deq_i,
  input  logic                              addr_we_i,
  input  logic [PTR_W-1:0]                  addr_idx_i,
  input  logic [VA_W-1:0]                   addr_va_i,
  input  logic [PA_W-1:0]                   addr_pa_i,
  input  logic [LANES-1:0]                  addr_mask_i,
  input  logic                              data_we_i,
  input  logic [PTR_W-1:0]                  data_idx_i,
  input  logic [DATA_W-1:0]                 data_i,
  output logic [SQ_N-1:0]                   alloc_v_o,
  output logic [SQ_N-1:0]                   addr_v_o,
  output logic [SQ_N-1:0]                   data_v_o,
  output logic [SQ_N-1:0][VA_W-1:0]         va_o,
  output logic [SQ_N-1:0][PA_W-1:0]         pa_o,
  output logic [SQ_N-1:0][LANES-1:0]        mask_o,
  output logic [SQ_N-1:0][DATA_W-1:0]       data_o
);
  logic [PTR_W-1:0] head_q, tail_q;
  logic [PTR_W:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (alloc_i) tail_q <= tail_q + 1'b1;
      if (deq_i)   head_q <= head_q + 1'b1;
      cnt_q <= cnt_q + (PTR_W+1)'(alloc_i) - (PTR_W+1)'(deq_i);
    end
  end

  for (genvar i = 0; i < SQ_N; i++) begin : g_ent
    logic al, fr;
    assign al = alloc_i && tail_q == PTR_W'(i);
    assign fr = deq_i && head_q == PTR_W'(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        alloc_v_o[i] <= 1'b0;
        addr_v_o[i]  <= 1'b0;
        data_v_o[i]  <= 1'b0;
      end else begin
        if (fr) alloc_v_o[i] <= 1'b0;
        if (al) begin
          alloc_v_o[i] <= 1'b1;
          addr_v_o[i]  <= 1'b0;
          data_v_o[i]  <= 1'b0;
        end
        if (addr_we_i && addr_idx_i == PTR_W'(i)) addr_v_o[i] <= 1'b1;
        if (data_we_i && data_idx_i == PTR_W'(i)) data_v_o[i] <= 1'b1;
      end
    end
    always_ff @(posedge clk_i) begin
      if (addr_we_i && addr_idx_i == PTR_W'(i)) begin
        va_o[i]   <= addr_va_i;
        pa_o[i]   <= addr_pa_i;
        mask_o[i] <= addr_mask_i;
      end
      if (data_we_i && data_idx_i == PTR_W'(i)) data_o[i] <= data_i;
    end
  end

  assign tail_o = tail_q;

  // R1
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i && !deq_i |-> cnt_q < (PTR_W+1)'(SQ_N));
  // R1
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_i |-> cnt_q != '0);
  // R1
  addr_to_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_we_i |-> alloc_v_o[addr_idx_i]);
  // R1
  freed_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_i && !alloc_i |=> !alloc_v_o[$past(head_q)]);
endmodule

// File: rtl/sfwd_match.sv
module sfwd_match
  import sfwd_pkg::*;
(
  input  logic [SQ_N-1:0]                   alloc_v_i,
  input  logic [SQ_N-1:0]                   addr_v_i,
  input  logic [SQ_N-1:0]                   data_v_i,
  input  logic [SQ_N-1:0][VA_W-1:0]         va_i,
  input  logic [SQ_N-1:0][PA_W-1:0]         pa_i,
  input  logic [SQ_N-1:0][LANES-1:0]        mask_i,
  input  logic [VA_W-1:0]                   ld_va_i,
  input  logic [PA_W-1:0]                   ld_pa_i,
  input  logic [LANES-1:0]                  ld_mask_i,
  input  logic [SQ_N-1:0]                   ld_older_i,
  input  logic [PTR_W-1:0]                  ld_pos_i,
  output logic [LANES-1:0]                  fast_hit_o,
  output logic                              fast_dnr_o,
  output logic [LANES-1:0]                  hit_o,
  output logic [LANES-1:0][PTR_W-1:0]       sel_o,
  output flags_t                            flags_o
);
  // youngest set bit walking down from pos-1, wrapping
  function automatic logic [PTR_W:0] pick(input logic [SQ_N-1:0] v,
                                          input logic [PTR_W-1:0] pos);
    logic [PTR_W-1:0] j;
    pick = '0;
    for (int k = SQ_N - 1; k >= 0; k--) begin
      j = pos - PTR_W'(1) - PTR_W'(k);
      if (v[j]) pick = {1'b1, j};
    end
  endfunction

  logic [SQ_N-1:0] base, va_m, pa_m, ovl;
  for (genvar i = 0; i < SQ_N; i++) begin : g_cam
    assign base[i] = ld_older_i[i] & alloc_v_i[i] & addr_v_i[i];
    assign va_m[i] = va_i[i][VA_W-1:LOFS] == ld_va_i[VA_W-1:LOFS];
    assign pa_m[i] = pa_i[i][PA_W-1:LOFS] == ld_pa_i[PA_W-1:LOFS];
    assign ovl[i]  = |(mask_i[i] & ld_mask_i);
  end

  logic [LANES-1:0] lane_dnr, lane_fdnr;
  logic [LANES-1:0][SQ_N-1:0] dnr_by_lane;
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [SQ_N-1:0] cp, cv;
    logic [PTR_W:0]  rp, rv;
    for (genvar i = 0; i < SQ_N; i++) begin : g_c
      assign cp[i] = base[i] & pa_m[i] & mask_i[i][b] & ld_mask_i[b];
      assign cv[i] = base[i] & va_m[i] & mask_i[i][b] & ld_mask_i[b];
    end
    assign rp = pick(cp, ld_pos_i);
    assign rv = pick(cv, ld_pos_i);
    assign sel_o[b]      = rp[PTR_W-1:0];
    assign hit_o[b]      = rp[PTR_W] & data_v_i[rp[PTR_W-1:0]];
    assign lane_dnr[b]   = rp[PTR_W] & ~data_v_i[rp[PTR_W-1:0]];
    assign fast_hit_o[b] = rv[PTR_W] & data_v_i[rv[PTR_W-1:0]];
    assign lane_fdnr[b]  = rv[PTR_W] & ~data_v_i[rv[PTR_W-1:0]];
    assign dnr_by_lane[b] = lane_dnr[b] ? (SQ_N'(1) << rp[PTR_W-1:0]) : '0;
  end

  logic [SQ_N-1:0] dnr_set;
  always_comb begin
    dnr_set = '0;
    for (int b = 0; b < LANES; b++) dnr_set |= dnr_by_lane[b];
  end

  logic [PTR_W:0] pd, pn;
  assign pd = pick(dnr_set, ld_pos_i);
  assign pn = pick(ld_older_i & alloc_v_i & ~addr_v_i, ld_pos_i);

  assign fast_dnr_o      = |lane_fdnr;
  assign flags_o.dnr     = pd[PTR_W];
  assign flags_o.dnr_idx = pd[PTR_W-1:0];
  assign flags_o.anr     = pn[PTR_W];
  assign flags_o.anr_idx = pn[PTR_W-1:0];
  assign flags_o.mm      = (base & va_m & ovl) != (base & pa_m & ovl);

  // R7
  dnr_lane_agree_chk: assert final (flags_o.dnr == (|lane_dnr));
  // R2
  hit_in_load_mask_chk: assert final ((hit_o & ~ld_mask_i) == '0);
endmodule

// File: rtl/sfwd_unit.sv
module sfwd_unit
  import sfwd_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flush_i,
  input  logic                 alloc_i,
  output logic [PTR_W-1:0]     alloc_idx_o,
  input  logic                 deq_i,
  input  logic                 addr_we_i,
  input  logic [PTR_W-1:0]     addr_idx_i,
  input  logic [VA_W-1:0]      addr_va_i,
  input  logic [PA_W-1:0]      addr_pa_i,
  input  logic [LANES-1:0]     addr_mask_i,
  input  logic                 data_we_i,
  input  logic [PTR_W-1:0]     data_idx_i,
  input  logic [DATA_W-1:0]    data_i,
  input  logic                 ld_valid_i,
  input  logic [VA_W-1:0]      ld_va_i,
  input  logic [PA_W-1:0]      ld_pa_i,
  input  logic [LANES-1:0]     ld_mask_i,
  input  logic [SQ_N-1:0]      ld_older_i,
  input  logic [PTR_W-1:0]     ld_pos_i,
  input  logic [DATA_W-1:0]    cache_data_i,
  output logic [LANES-1:0]     fast_hit_o,
  output logic                 fast_data_nr_o,
  output logic                 resp_valid_o,
  output logic [LANES-1:0]     hit_o,
  output logic [DATA_W-1:0]    data_o,
  output logic                 data_nr_o,
  output logic [PTR_W-1:0]     data_nr_idx_o,
  output logic                 addr_nr_o,
  output logic [PTR_W-1:0]     addr_nr_idx_o,
  output logic                 mismatch_o
);
  logic [SQ_N-1:0]             alloc_v, addr_v, data_v;
  logic [SQ_N-1:0][VA_W-1:0]   st_va;
  logic [SQ_N-1:0][PA_W-1:0]   st_pa;
  logic [SQ_N-1:0][LANES-1:0]  st_mask;
  logic [SQ_N-1:0][DATA_W-1:0] st_data;

  sfwd_store_queue i_queue (
    .clk_i, .rst_ni, .alloc_i, .tail_o(alloc_idx_o), .deq_i,
    .addr_we_i, .addr_idx_i, .addr_va_i, .addr_pa_i, .addr_mask_i,
    .data_we_i, .data_idx_i, .data_i,
    .alloc_v_o(alloc_v), .addr_v_o(addr_v), .data_v_o(data_v),
    .va_o(st_va), .pa_o(st_pa), .mask_o(st_mask), .data_o(st_data)
  );

  logic [LANES-1:0]            m_fhit, m_hit;
  logic                        m_fdnr;
  logic [LANES-1:0][PTR_W-1:0] m_sel;
  flags_t                      m_flags;

  sfwd_match i_match (
    .alloc_v_i(alloc_v), .addr_v_i(addr_v), .data_v_i(data_v),
    .va_i(st_va), .pa_i(st_pa), .mask_i(st_mask),
    .ld_va_i, .ld_pa_i, .ld_mask_i, .ld_older_i, .ld_pos_i,
    .fast_hit_o(m_fhit), .fast_dnr_o(m_fdnr), .hit_o(m_hit),
    .sel_o(m_sel), .flags_o(m_flags)
  );

  // stage 1
  logic                        s1_v;
  logic [LANES-1:0]            s1_fhit, s1_hit;
  logic                        s1_fdnr;
  logic [LANES-1:0][PTR_W-1:0] s1_sel;
  flags_t                      s1_flags;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v <= 1'b0; s1_fhit <= '0; s1_hit <= '0; s1_fdnr <= 1'b0;
      s1_sel <= '0; s1_flags <= '0;
    end else if (flush_i || !ld_valid_i) begin
      s1_v <= 1'b0; s1_fhit <= '0; s1_hit <= '0; s1_fdnr <= 1'b0;
      s1_sel <= '0; s1_flags <= '0;
    end else begin
      s1_v <= 1'b1; s1_fhit <= m_fhit; s1_hit <= m_hit; s1_fdnr <= m_fdnr;
      s1_sel <= m_sel; s1_flags <= m_flags;
    end
  end

  assign fast_hit_o     = s1_fhit;
  assign fast_data_nr_o = s1_fdnr;

  // stage 2: byte merge
  logic [DATA_W-1:0] merged;
  for (genvar b = 0; b < LANES; b++) begin : g_mrg
    assign merged[8*b +: 8] = s1_hit[b] ? st_data[s1_sel[b]][8*b +: 8]
                                        : cache_data_i[8*b +: 8];
  end

  flags_t s2_flags;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0; hit_o <= '0; data_o <= '0; s2_flags <= '0;
    end else if (flush_i || !s1_v) begin
      resp_valid_o <= 1'b0; hit_o <= '0; data_o <= '0; s2_flags <= '0;
    end else begin
      resp_valid_o <= 1'b1; hit_o <= s1_hit; data_o <= merged;
      s2_flags <= s1_flags;
    end
  end

  assign data_nr_o     = s2_flags.dnr;
  assign data_nr_idx_o = s2_flags.dnr_idx;
  assign addr_nr_o     = s2_flags.anr;
  assign addr_nr_idx_o = s2_flags.anr_idx;
  assign mismatch_o    = s2_flags.mm;

  // R10
  flush_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !resp_valid_o && fast_hit_o == '0);
  // R6
  stage_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i && !flush_i ##1 !flush_i |=> resp_valid_o);
  // R5
  fast_in_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i |=> (fast_hit_o & ~$past(ld_mask_i)) == '0);
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_valid_i |=> fast_hit_o == '0 && !fast_data_nr_o);
endmodule

// File: tb/test_sfwd_unit.sv
module test_sfwd_unit;
  import sfwd_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic flush, alloc, deq, awe, dwe, ldv;
  logic [3:0] aidx, didx, lpos, alloc_idx, dnr_idx, anr_idx;
  logic [38:0] ava, lva;
  logic [35:0] apa, lpa;
  logic [15:0] amask, lmask, lolder, fhit, hit;
  logic [127:0] dat, cdat, dout;
  logic fdnr, rv, dnr, anr, mm;

  sfwd_unit i_sfwd_unit (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .alloc_i(alloc),
    .alloc_idx_o(alloc_idx), .deq_i(deq), .addr_we_i(awe), .addr_idx_i(aidx),
    .addr_va_i(ava), .addr_pa_i(apa), .addr_mask_i(amask), .data_we_i(dwe),
    .data_idx_i(didx), .data_i(dat), .ld_valid_i(ldv), .ld_va_i(lva),
    .ld_pa_i(lpa), .ld_mask_i(lmask), .ld_older_i(lolder), .ld_pos_i(lpos),
    .cache_data_i(cdat), .fast_hit_o(fhit), .fast_data_nr_o(fdnr),
    .resp_valid_o(rv), .hit_o(hit), .data_o(dout), .data_nr_o(dnr),
    .data_nr_idx_o(dnr_idx), .addr_nr_o(anr), .addr_nr_idx_o(anr_idx),
    .mismatch_o(mm)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference queue
  bit m_al[16], m_av[16], m_dv[16];
  logic [38:0] m_va[16];
  logic [35:0] m_pa[16];
  logic [15:0] m_mk[16];
  logic [127:0] m_dt[16];
  int head = 0, tail = 0, cnt = 0;

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic int pick(input logic [15:0] v, input int pos);
    for (int k = 0; k < 16; k++) begin
      int j = (pos - 1 - k + 32) % 16;
      if (v[j]) return j;
    end
    return -1;
  endfunction

  task automatic idle();
    flush = 0; alloc = 0; deq = 0; awe = 0; dwe = 0; ldv = 0;
  endtask

  task automatic do_alloc();
    chk("R1 alloc index", 128'(alloc_idx), 128'(tail));
    alloc = 1;
    @(negedge clk); alloc = 0;
    m_al[tail] = 1; m_av[tail] = 0; m_dv[tail] = 0;
    tail = (tail + 1) % 16; cnt++;
  endtask

  task automatic do_deq();
    deq = 1;
    @(negedge clk); deq = 0;
    m_al[head] = 0; head = (head + 1) % 16; cnt--;
  endtask

  task automatic do_addr(input int i, input logic [38:0] va, input logic [35:0] pa,
                         input logic [15:0] mk);
    awe = 1; aidx = 4'(i); ava = va; apa = pa; amask = mk;
    @(negedge clk); awe = 0;
    m_av[i] = 1; m_va[i] = va; m_pa[i] = pa; m_mk[i] = mk;
  endtask

  task automatic do_data(input int i, input logic [127:0] d);
    dwe = 1; didx = 4'(i); dat = d;
    @(negedge clk); dwe = 0;
    m_dv[i] = 1; m_dt[i] = d;
  endtask

  // query with load position head+k; all checks from the model
  task automatic do_query(input int k, input logic [38:0] va, input logic [35:0] pa,
                          input logic [15:0] mk);
    logic [15:0] older = '0, ehit = '0, efhit = '0, dset = '0, nset = '0;
    logic [15:0] bset = '0, vs = '0, ps = '0;
    logic [127:0] ed;
    bit efdnr = 0;
    int pos = (head + k) % 16;
    for (int j = 0; j < k; j++) older[(head + j) % 16] = 1'b1;
    for (int i = 0; i < 16; i++) begin
      bset[i] = older[i] && m_al[i] && m_av[i];
      nset[i] = older[i] && m_al[i] && !m_av[i];
      if (bset[i] && (m_mk[i] & mk) != 0) begin
        vs[i] = m_va[i][38:4] == va[38:4];
        ps[i] = m_pa[i][35:4] == pa[35:4];
      end
    end
    ed = {$urandom, $urandom, $urandom, $urandom};
    cdat = ed;
    for (int b = 0; b < 16; b++) begin
      logic [15:0] cp = '0, cv = '0;
      int sp, sv;
      for (int i = 0; i < 16; i++) begin
        cp[i] = bset[i] && mk[b] && m_mk[i][b] && m_pa[i][35:4] == pa[35:4];
        cv[i] = bset[i] && mk[b] && m_mk[i][b] && m_va[i][38:4] == va[38:4];
      end
      sp = pick(cp, pos); sv = pick(cv, pos);
      if (sp >= 0) begin
        if (m_dv[sp]) begin ehit[b] = 1; ed[8*b +: 8] = m_dt[sp][8*b +: 8]; end
        else dset[sp] = 1;
      end
      if (sv >= 0) begin
        if (m_dv[sv]) efhit[b] = 1; else efdnr = 1;
      end
    end
    ldv = 1; lva = va; lpa = pa; lmask = mk; lolder = older; lpos = 4'(pos);
    @(negedge clk); ldv = 0;
    chk("R5 fast hit", 128'(fhit), 128'(efhit));
    chk("R5 fast data-not-ready", 128'(fdnr), 128'(efdnr));
    @(negedge clk);
    chk("R6 resp valid", 128'(rv), 128'(1));
    chk("R6 hit mask", 128'(hit), 128'(ehit));
    chk("R4 merged data", dout, ed);
    chk("R7 data-not-ready", 128'(dnr), 128'(dset != 0));
    if (dset != 0) chk("R7 data-not-ready index", 128'(dnr_idx), 128'(pick(dset, pos)));
    chk("R8 addr-not-ready", 128'(anr), 128'(nset != 0));
    if (nset != 0) chk("R8 addr-not-ready index", 128'(anr_idx), 128'(pick(nset, pos)));
    chk("R9 mismatch", 128'(mm), 128'(vs != ps));
  endtask

  function automatic logic [15:0] rnd_mask();
    int s = $urandom % 5;
    int off = ($urandom % (16 >> s)) << s;
    return 16'(((32'd1 << (1 << s)) - 1) << off);
  endfunction

  function automatic logic [38:0] lva_of(input int l);
    return 39'h40_0000_0000 + 39'(l * 16) + 39'($urandom % 16);
  endfunction
  function automatic logic [35:0] lpa_of(input int l);
    return 36'h8_0000_0000 + 36'(l * 16 + 16'h100) + 36'($urandom % 16);
  endfunction

  initial begin
    void'($urandom(32'h5f0d));
    idle(); aidx = 0; didx = 0; ava = 0; apa = 0; amask = 0; dat = 0;
    lva = 0; lpa = 0; lmask = 0; lolder = 0; lpos = 0; cdat = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 alloc index", 128'(alloc_idx), 128'(0));
    chk("R11 resp valid", 128'(rv), 128'(0));
    chk("R11 hit", 128'(hit), 128'(0));
    rst_n = 1;
    @(negedge clk);

    // directed: R3 youngest wins, R2 line match
    do_alloc(); do_alloc(); do_alloc();
    do_addr(0, lva_of(1), lpa_of(1), 16'h00ff); do_data(0, {16{8'h11}});
    do_addr(1, lva_of(1), lpa_of(1), 16'h0ff0); do_data(1, {16{8'h22}});
    do_addr(2, lva_of(2), lpa_of(2), 16'hffff); do_data(2, {16{8'h33}});
    do_query(3, lva_of(1), lpa_of(1), 16'hffff);   // R3 entry 1 over 0, R2 skip 2
    do_query(1, lva_of(1), lpa_of(1), 16'hffff);   // R3 only entry 0 older
    // R7/R8 directed
    do_alloc(); do_alloc();
    do_addr(3, lva_of(1), lpa_of(1), 16'h000f);
    do_query(5, lva_of(1), lpa_of(1), 16'h00ff);
    // R9 mismatch: same virtual line, other physical line
    do_addr(4, lva_of(1), lpa_of(3), 16'h0f00); do_data(4, {16{8'h55}});
    do_query(5, lva_of(1), lpa_of(1), 16'hffff);
    // R10 flush
    ldv = 1; lva = lva_of(1); lpa = lpa_of(1); lmask = 16'hffff; lolder = 16'h001f; lpos = 5;
    @(negedge clk); ldv = 0; flush = 1;
    @(negedge clk); flush = 0;
    chk("R10 flush resp valid", 128'(rv), 128'(0));
    chk("R10 flush hit", 128'(hit), 128'(0));
    // R10 invalid query
    lolder = 16'h001f;
    @(negedge clk); @(negedge clk);
    chk("R10 idle fast hit", 128'(fhit), 128'(0));
    chk("R10 idle resp", 128'(rv), 128'(0));

    // random mix, wraps the pointers (R1 R2 R3 R4)
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom % 10;
      if (op < 2 && cnt < 16) do_alloc();
      else if (op == 2 && cnt > 0 && ($urandom % 3 == 0 || cnt > 12)) do_deq();
      else if (op < 5 && cnt > 0) begin
        int l = $urandom % 4;
        do_addr((head + $urandom % cnt) % 16, lva_of(l), lpa_of(($urandom % 16 == 0) ? 3 - l : l), rnd_mask());
      end else if (op < 7 && cnt > 0) begin
        int e = (head + $urandom % cnt) % 16;
        if (m_av[e]) do_data(e, {$urandom, $urandom, $urandom, $urandom});
      end else begin
        int l = $urandom % 4;
        do_query($urandom % (cnt + 1), lva_of(l), lpa_of(l), rnd_mask());
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule